// File: doc/BRIEF.md
# Indirect Register Bridge with Scratch RAM

This block gives a host access to a small set of internal registers and a 64-byte scratch RAM through only two host-side registers: an index register and a data register. The host picks an internal register by writing its number into the index register. It then writes the data register to store a value, or sets bit 7 of the index register to fetch one. Every internal access is a transfer that takes several cycles. Bit 7 of the index register reads back as a busy flag, and the host polls it until the transfer is over.

The internal space holds three registers. The first is a control register whose top bit drives an enable output. The second is a 6-bit RAM pointer. The third is a RAM data port that steps the pointer after every access. Because of that step, a block of RAM can be filled or dumped with the pointer set only once.

Top module: `ind_reg_bridge`

## Requirements
- R1: `idxRd` reads back `{busy, index[6:0]}`. A write to the index register with bit 7 clear only loads the index and leaves busy at 0.
- R2: A data-register write (`datWe`) while not busy starts a write transfer. Busy then reads 1 for exactly 4 cycles, the first of them the cycle after the strobe. When busy clears, the value has been written to the selected internal register, and `datRd` holds the written value.
- R3: An index-register write with bit 7 set, while not busy, loads `index` from bits 6:0 and starts a read transfer. Busy lasts 4 cycles, and `datRd` then holds the value read.
- R4: While busy is 1, index writes, read requests and data writes are all ignored. The index, the data register and every internal register keep their values.
- R5: Index 0x06 is the control register. A write sets `clockEnable` to data bit 7. A read returns `{clockEnable, 7'b0}`, so writing 0x80 turns the enable on.
- R6: Index 0x0E is the RAM pointer. A write loads data bits 5:0, and a read returns `{2'b00, pointer}`.
- R7: Index 0x0F is the RAM data port. A write stores the byte at the pointer, and a read returns the byte at the pointer. Either access then advances the pointer by one.
- R8: The pointer wraps from 63 to 0.
- R9: Any other index reads as 0x00. A write to it changes no register and no RAM byte.
- R10: Synchronous reset clears the index, busy, the data register, the control register and the pointer. RAM contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idxWe | input | 1 | Index register write strobe |
| idxWdata | input | 8 | Index write value. Bit 7 requests a read. |
| datWe | input | 1 | Data register write strobe. It starts a write transfer. |
| datWdata | input | 8 | Data write value |
| idxRd | output | 8 | Index register readback: `{busy, index}` |
| datRd | output | 8 | Data register readback |
| clockEnable | output | 1 | Enable bit of the control register |

## Verification
The hardest case to reach is a host write that lands in the middle of a transfer and has to be dropped. A well-behaved host never does this, so it cannot happen while the host is polling. The stimulus therefore injects a combined index write, read request and data write on the second busy cycle of selected transfers. It then checks that the index, the data register and the modelled register and RAM contents show no trace of them. Pointer wrap is reached directly, by placing the pointer at 62 and then streaming bytes across the boundary. Retention of RAM contents is tested by applying reset after the RAM has been filled.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = DATA_W - 1;
  localparam logic [IDX_W-1:0] CTRL_IDX = 7'h06;
  localparam logic [IDX_W-1:0] PTR_IDX  = 7'h0E;
  localparam logic [IDX_W-1:0] PORT_IDX = 7'h0F;

  typedef struct packed {
    logic loadIdx;
    logic loadData;
    logic commitWr;
    logic commitRd;
  } bridge_stb_t;
endpackage

// File: rtl/ind_bridge_ctrl.sv
module ind_bridge_ctrl
  import ind_bridge_pkg::*;
#(
  parameter int BUSY_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        idxWe,
  input  logic        rdReq,
  input  logic        datWe,
  output logic        busy,
  output bridge_stb_t stb
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             isRd;
  logic             lastCyc;

  assign lastCyc = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      isRd <= 1'b0;
    end else if (!busy) begin
      if (datWe || (idxWe && rdReq)) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(BUSY_CYC - 1);
        isRd <= !datWe;
      end
    end else if (lastCyc) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    stb.loadIdx  = idxWe && !busy;
    stb.loadData = datWe && !busy;
    stb.commitWr = lastCyc && !isRd;
    stb.commitRd = lastCyc && isRd;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && datWe) |=> busy);
  p_read_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && idxWe && rdReq) |=> busy);
  p_select_only_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && idxWe && !rdReq && !datWe) |=> !busy);
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> !busy);
endmodule

// File: rtl/ind_bridge_dp.sv
module ind_bridge_dp
  import ind_bridge_pkg::*;
#(
  parameter int RAM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  bridge_stb_t       stb,
  input  logic [DATA_W-1:0] idxWdata,
  input  logic [DATA_W-1:0] datWdata,
  output logic [IDX_W-1:0]  index,
  output logic [DATA_W-1:0] dataReg,
  output logic              ctrlEn
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] mem [RAM_DEPTH];
  logic [RAM_AW-1:0] ptr;
  logic [DATA_W-1:0] rdVal;
  logic              portHit;

  assign portHit = (index == PORT_IDX);

  always_comb begin
    case (index)
      CTRL_IDX: rdVal = {ctrlEn, {(DATA_W-1){1'b0}}};
      PTR_IDX:  rdVal = {{(DATA_W-RAM_AW){1'b0}}, ptr};
      PORT_IDX: rdVal = mem[ptr];
      default:  rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index   <= '0;
      dataReg <= '0;
      ctrlEn  <= 1'b0;
      ptr     <= '0;
    end else begin
      if (stb.loadIdx)  index   <= idxWdata[IDX_W-1:0];
      if (stb.loadData) dataReg <= datWdata;
      if (stb.commitRd) dataReg <= rdVal;
      if (stb.commitWr) begin
        if (index == CTRL_IDX) ctrlEn <= dataReg[DATA_W-1];
        if (index == PTR_IDX)  ptr    <= dataReg[RAM_AW-1:0];
      end
      if ((stb.commitWr || stb.commitRd) && portHit) ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && stb.commitWr && portHit) mem[ptr] <= dataReg;
  end

  p_hold_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !stb.commitRd) |=> $stable(dataReg));
  p_index_hold_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(index));
  p_enable_load_r5: assert property (@(posedge clk) disable iff (rst)
    (stb.commitWr && index == CTRL_IDX) |=> ctrlEn == $past(dataReg[DATA_W-1]));
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    ((stb.commitWr || stb.commitRd) && portHit && ptr == '1) |=> ptr == '0);
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (ptr == '0 && !ctrlEn && index == '0));
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_bridge_pkg::*;
#(
  parameter int BUSY_CYC = 4,
  parameter int RAM_AW   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idxWe,
  input  logic [7:0] idxWdata,
  input  logic       datWe,
  input  logic [7:0] datWdata,
  output logic [7:0] idxRd,
  output logic [7:0] datRd,
  output logic       clockEnable
);
  logic             busy;
  bridge_stb_t      stb;
  logic [IDX_W-1:0] index;

  ind_bridge_ctrl #(.BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .idxWe (idxWe),
    .rdReq (idxWdata[DATA_W-1]),
    .datWe (datWe),
    .busy  (busy),
    .stb   (stb)
  );

  ind_bridge_dp #(.RAM_AW(RAM_AW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .stb      (stb),
    .idxWdata (idxWdata),
    .datWdata (datWdata),
    .index    (index),
    .dataReg  (datRd),
    .ctrlEn   (clockEnable)
  );

  assign idxRd = {busy, index};
endmodule

// File: tb/ind_reg_bridge_tb.sv
module ind_reg_bridge_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       idxWe = 0;
  logic [7:0] idxWdata = 0;
  logic       datWe = 0;
  logic [7:0] datWdata = 0;
  logic [7:0] idxRd, datRd;
  logic       clockEnable;

  int checks = 0;
  int errors = 0;

  logic [7:0] mMem [64];
  logic [5:0] mPtr = 0;
  logic       mEn = 0;
  logic [6:0] mIdx = 0;

  ind_reg_bridge u_dut (
    .clk(clk), .rst(rst), .idxWe(idxWe), .idxWdata(idxWdata),
    .datWe(datWe), .datWdata(datWdata), .idxRd(idxRd), .datRd(datRd),
    .clockEnable(clockEnable)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(logic [6:0] i);
    case (i)
      7'h06:   return {mEn, 7'b0};
      7'h0E:   return {2'b00, mPtr};
      7'h0F:   return mMem[mPtr];
      default: return 8'h00;
    endcase
  endfunction

  task automatic pulseIdx(logic [7:0] v);
    @(negedge clk); idxWe = 1; idxWdata = v;
    @(negedge clk); idxWe = 0;
  endtask

  task automatic pulseDat(logic [7:0] v);
    @(negedge clk); datWe = 1; datWdata = v;
    @(negedge clk); datWe = 0;
  endtask

  task automatic waitDone(string req, bit inject);
    int cyc = 0;
    while (idxRd[7] && cyc < 20) begin
      cyc++;
      if (inject && cyc == 2) begin
        idxWe = 1; idxWdata = 8'hFF; datWe = 1; datWdata = 8'h5A;
      end
      @(negedge clk);
      idxWe = 0; datWe = 0;
    end
    check({req, " busy cycles"}, 8'(cyc), 8'd4);
    check({req, " R4 index kept"}, idxRd, {1'b0, mIdx});
  endtask

  task automatic sel(logic [6:0] i);
    pulseIdx({1'b0, i});
    mIdx = i;
    check("R1 select only", idxRd, {1'b0, i});
  endtask

  task automatic doWr(logic [6:0] i, logic [7:0] d, bit inject);
    sel(i);
    pulseDat(d);
    waitDone("R2", inject);
    case (i)
      7'h06: mEn = d[7];
      7'h0E: mPtr = d[5:0];
      7'h0F: begin mMem[mPtr] = d; mPtr = mPtr + 1; end
      default: ;
    endcase
    check("R2 data reg keeps write", datRd, d);
    check("R5 enable output", {7'b0, clockEnable}, {7'b0, mEn});
  endtask

  task automatic doRd(logic [6:0] i, bit inject, string req);
    logic [7:0] exp;
    exp = modelRead(i);
    pulseIdx({1'b1, i});
    mIdx = i;
    waitDone("R3", inject);
    if (i == 7'h0F) mPtr = mPtr + 1;
    check(req, datRd, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst = 0;
    check("R10 reset index", idxRd, 8'h00);
    check("R10 reset data", datRd, 8'h00);
    check("R10 reset enable", {7'b0, clockEnable}, 8'h00);

    doWr(7'h06, 8'h80, 0);
    check("R5 enable on", {7'b0, clockEnable}, 8'h01);
    doRd(7'h06, 0, "R5 ctrl readback");

    doWr(7'h0E, 8'h00, 0);
    for (int k = 0; k < 64; k++) doWr(7'h0F, 8'(k * 37 + 5), k % 9 == 3);
    doRd(7'h0E, 0, "R8 pointer wrapped to 0");
    for (int k = 0; k < 64; k++) doRd(7'h0F, k % 11 == 4, "R7 port read");

    doWr(7'h0E, 8'hFE, 0);
    doRd(7'h0E, 0, "R6 pointer loads low bits");
    doWr(7'h0F, 8'hC3, 0);
    doWr(7'h0F, 8'h3C, 0);
    doRd(7'h0E, 0, "R8 wrap after 63");
    doWr(7'h0E, 8'h3E, 0);
    doRd(7'h0F, 0, "R7 read byte 62");
    doRd(7'h0F, 0, "R8 read byte 63");
    doRd(7'h0E, 0, "R8 read wrap");

    doWr(7'h23, 8'hEE, 0);
    doRd(7'h23, 0, "R9 unused reads zero");
    doRd(7'h0E, 0, "R9 pointer untouched");

    doWr(7'h06, 8'h80, 1);
    doWr(7'h0E, 8'h05, 1);
    doRd(7'h0E, 1, "R4 injected writes ignored");

    for (int n = 0; n < 300; n++) begin
      logic [6:0] i;
      logic [2:0] pick = 3'($urandom_range(0, 4));
      i = (pick == 0) ? 7'h06 : (pick == 1) ? 7'h0E :
          (pick == 4) ? 7'($urandom) : 7'h0F;
      if ($urandom_range(0, 1) == 1)
        doWr(i, 8'($urandom), $urandom_range(0, 5) == 0);
      else
        doRd(i, $urandom_range(0, 5) == 0, "R7 random read");
    end

    doWr(7'h06, 8'h80, 0);
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    mPtr = 0; mEn = 0; mIdx = 0;
    check("R10 reset index", idxRd, 8'h00);
    check("R10 reset data", datRd, 8'h00);
    check("R10 reset enable", {7'b0, clockEnable}, 8'h00);
    doRd(7'h0E, 0, "R10 pointer cleared");
    for (int k = 0; k < 64; k++) doRd(7'h0F, 0, "R10 RAM kept");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule